// File: doc/BRIEF.md
# Lane-Serialized SIMD Warp Executor

This block runs one integer instruction over all 32 thread lanes of a warp while using only 8 physical ALUs. The lanes are shared out over time. The instruction and its operands are captured once through a valid/ready handshake. The 8 units then work through the warp in four consecutive beats, each beat covering one contiguous group of 8 lanes. The finished 32-lane result vector is held in a register, and a one-cycle done strobe marks the point where it is complete.

Each lane holds its two operands packed into wide vectors. A per-lane active mask selects which lanes are written. A masked-off lane keeps whatever result it last held, so a caller can build up a vector across several instructions with different masks. The block takes a new instruction in the same cycle that it raises done, which gives one instruction every five clocks when the caller keeps it busy.

Top module: `warp_lane_serial_exec`

## Requirements
- R1: `in_ready` is high whenever no instruction is in progress. An instruction is taken at a rising clock edge where both `in_valid` and `in_ready` are high.
- R2: After the taking edge, `in_ready` stays low for exactly four cycles. Any `in_valid` and operand values presented in those cycles are ignored and do not change the results.
- R3: If an instruction is taken at edge n, `out_done` is high for exactly the single cycle that follows edge n+4. At that point every active lane of `out_result` holds its final value.
- R4: At edge n+1+k (k = 0..3), the result register writes lanes 8k through 8k+7. Lane i sits in bits [32i+31:32i] of every lane vector, and it is handled by unit i mod 8 in beat i div 8.
- R5: Opcode 0 gives A+B, 1 gives A−B, 2 gives A AND B, 3 gives A OR B, and 4 gives A XOR B. All are 32-bit modulo operations.
- R6: Opcode 5 gives A shifted left by B[4:0]. The upper bits of B are ignored.
- R7: Opcodes 6 and 7 write zero to the active lanes.
- R8: A lane whose `in_mask` bit was 0 when the instruction was taken keeps its previous result value.
- R9: While `rst_n` is low, and after it is released, `out_result` is all zero, `out_done` is low and `in_ready` is high.
- R10: The block can take a new instruction at the edge that ends the cycle in which `out_done` is high. Back-to-back instructions therefore start five cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| in_op | input | 3 | Operation code |
| in_a | input | 1024 | Operand A, 32 lanes of 32 bits |
| in_b | input | 1024 | Operand B, 32 lanes of 32 bits |
| in_mask | input | 32 | Active-lane mask, bit i for lane i |
| out_done | output | 1 | One-cycle completion strobe |
| out_result | output | 1024 | Registered 32-lane result vector |

## Verification
Every result follows a fixed schedule. If the taking edge is n, `in_ready` falls right after edge n. Lane group k updates right after edge n+1+k. `out_done` and the full vector are due right after edge n+4, and `in_ready` comes back high in that same cycle. The bench drives its stimulus on falling edges. It advances a behavioural model on each rising edge, and that model moves through the four beats of the current instruction. At every falling edge it compares `in_ready`, `out_done` and the whole result vector against the model. A lane group that updates one edge too early or too late therefore shows up as a mismatch in that same cycle.

// File: rtl/warp_exec_pkg.sv
package warp_exec_pkg;

  typedef enum logic [2:0] {
    WX_ADD  = 3'd0,
    WX_SUB  = 3'd1,
    WX_AND  = 3'd2,
    WX_OR   = 3'd3,
    WX_XOR  = 3'd4,
    WX_SHL  = 3'd5,
    WX_RES6 = 3'd6,
    WX_RES7 = 3'd7
  } wx_op_e;

endpackage

// File: rtl/wx_lane_alu.sv
module wx_lane_alu
  import warp_exec_pkg::*;
#(
  parameter int DW = 32
) (
  input  wx_op_e          op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y
);
  localparam int SHW = (DW > 1) ? $clog2(DW) : 1;

  // Per-lane integer operation, purely combinational (R5, R6, R7)
  always_comb begin
    unique case (op)
      WX_ADD:  y = a + b;
      WX_SUB:  y = a - b;
      WX_AND:  y = a & b;
      WX_OR:   y = a | b;
      WX_XOR:  y = a ^ b;
      WX_SHL:  y = a << b[SHW-1:0];
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/wx_beat_sequencer.sv
module wx_beat_sequencer #(
  parameter int BEATS = 4,
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [BW-1:0] beat,
  output logic          done,
  output logic          ready
);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic          busy_q, busy_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    done_d = 1'b0;
    if (busy_q) begin
      if (beat_q == LAST) begin
        busy_d = 1'b0;
        beat_d = '0;
        done_d = 1'b1;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      beat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      done_q <= done_d;
    end
  end

  assign busy  = busy_q;
  assign beat  = beat_q;
  assign done  = done_q;
  assign ready = ~busy_q;

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);
  assert_beat_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && beat != LAST) |=> (busy && beat == $past(beat) + 1'b1));
endmodule

// File: rtl/wx_result_bank.sv
module wx_result_bank #(
  parameter int LANES = 32,
  parameter int UNITS = 8,
  parameter int DW    = 32,
  localparam int BEATS = LANES / UNITS,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busy,
  input  logic [BW-1:0]          beat,
  input  logic [LANES-1:0]       mask,
  input  logic [UNITS*DW-1:0]    unit_y,
  output logic [LANES*DW-1:0]    result
);
  logic [LANES*DW-1:0] res_q, res_d;

  // Only the lane group of the current beat is written, and only active lanes
  always_comb begin
    res_d = res_q;
    if (busy) begin
      for (int u = 0; u < UNITS; u++) begin
        if (mask[int'(beat) * UNITS + u]) begin
          res_d[(int'(beat) * UNITS + u) * DW +: DW] = unit_y[u * DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign result = res_q;

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));
endmodule

// File: rtl/warp_lane_serial_exec.sv
module warp_lane_serial_exec
  import warp_exec_pkg::*;
#(
  parameter int LANES = 32,
  parameter int UNITS = 8,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          in_op,
  input  logic [LANES*DW-1:0] in_a,
  input  logic [LANES*DW-1:0] in_b,
  input  logic [LANES-1:0]    in_mask,
  output logic                out_done,
  output logic [LANES*DW-1:0] out_result
);
  localparam int BEATS = LANES / UNITS;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int VW    = LANES * DW;

  logic          accept;
  logic          busy;
  logic [BW-1:0] beat;

  wx_op_e             op_q, op_d;
  logic [VW-1:0]      a_q, a_d, b_q, b_d;
  logic [LANES-1:0]   mask_q, mask_d;
  logic [UNITS*DW-1:0] unit_y;

  assign accept = in_valid & in_ready;

  // Operand capture with explicit enable on the accepting edge
  always_comb begin
    op_d   = op_q;
    a_d    = a_q;
    b_d    = b_q;
    mask_d = mask_q;
    if (accept) begin
      op_d   = wx_op_e'(in_op);
      a_d    = in_a;
      b_d    = in_b;
      mask_d = in_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= WX_ADD;
      a_q    <= '0;
      b_q    <= '0;
      mask_q <= '0;
    end else begin
      op_q   <= op_d;
      a_q    <= a_d;
      b_q    <= b_d;
      mask_q <= mask_d;
    end
  end

  wx_beat_sequencer #(.BEATS(BEATS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .beat  (beat),
    .done  (out_done),
    .ready (in_ready)
  );

  // Unit u serves lane beat*UNITS+u
  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [DW-1:0] opa, opb;
    always_comb begin
      opa = a_q[(int'(beat) * UNITS + u) * DW +: DW];
      opb = b_q[(int'(beat) * UNITS + u) * DW +: DW];
    end
    wx_lane_alu #(.DW(DW)) u_alu (
      .op (op_q),
      .a  (opa),
      .b  (opb),
      .y  (unit_y[u * DW +: DW])
    );
  end

  wx_result_bank #(.LANES(LANES), .UNITS(UNITS), .DW(DW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .beat   (beat),
    .mask   (mask_q),
    .unit_y (unit_y),
    .result (out_result)
  );

  assert_operands_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q) && $stable(mask_q)));
  assert_no_done_while_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !out_done) |=> !out_done);
endmodule

// File: tb/sim_warp_lane_serial_exec.sv
module sim_warp_lane_serial_exec;
  localparam int L  = 32;
  localparam int U  = 8;
  localparam int W  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [2:0]      in_op = '0;
  logic [L*W-1:0]  in_a = '0;
  logic [L*W-1:0]  in_b = '0;
  logic [L-1:0]    in_mask = '0;
  logic            out_done;
  logic [L*W-1:0]  out_result;

  always #10 clk = ~clk;

  warp_lane_serial_exec u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_mask(in_mask),
    .out_done(out_done), .out_result(out_result)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string cur_tag = "R5";

  // Behavioural reference model
  logic [W-1:0] m_res [L];
  logic [W-1:0] m_a [L];
  logic [W-1:0] m_b [L];
  logic [L-1:0] m_mask;
  int           m_op;
  bit           m_busy = 0;
  int           m_beat = 0;
  bit           m_done = 0;

  function automatic logic [W-1:0] ref_op(int op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a << b[4:0];
      default: return '0;
    endcase
  endfunction

  initial for (int i = 0; i < L; i++) m_res[i] = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_beat = 0; m_done = 0;
      for (int i = 0; i < L; i++) m_res[i] = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        for (int u = 0; u < U; u++) begin
          int ln;
          ln = m_beat * U + u;
          if (m_mask[ln]) m_res[ln] = ref_op(m_op, m_a[ln], m_b[ln]);
        end
        if (m_beat == 3) begin m_busy = 0; m_done = 1; m_beat = 0; end
        else m_beat++;
      end else if (in_valid) begin
        for (int i = 0; i < L; i++) begin
          m_a[i] = in_a[i*W +: W];
          m_b[i] = in_b[i*W +: W];
        end
        m_mask = in_mask;
        m_op   = int'(in_op);
        m_busy = 1;
        m_beat = 0;
      end
    end
  end

  function automatic logic [L*W-1:0] pack_ref();
    logic [L*W-1:0] v;
    for (int i = 0; i < L; i++) v[i*W +: W] = m_res[i];
    return v;
  endfunction

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      string tr;
      logic [L*W-1:0] ev;
      tr = m_done ? "R10" : (m_busy ? "R2" : "R1");
      if (!rst_n) tr = "R9";
      checks++;
      if (in_ready !== !m_busy) begin
        fails++;
        $display("FAIL %s in_ready actual=%b expected=%b t=%0t", tr, in_ready, !m_busy, $time);
      end
      checks++;
      if (out_done !== m_done) begin
        fails++;
        $display("FAIL %s out_done actual=%b expected=%b t=%0t", rst_n ? "R3" : "R9", out_done, m_done, $time);
      end
      ev = pack_ref();
      tr = !rst_n ? "R9" : (m_busy ? "R4" : cur_tag);
      checks++;
      if (out_result !== ev) begin
        fails++;
        $display("FAIL %s out_result actual=%h expected=%h t=%0t", tr, out_result, ev, $time);
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic fill(int mode);
    for (int i = 0; i < L; i++) begin
      case (mode)
        0: begin in_a[i*W +: W] = $urandom; in_b[i*W +: W] = $urandom; end
        1: begin in_a[i*W +: W] = 32'hFFFF_FFFF; in_b[i*W +: W] = 32'h1; end
        default: begin in_a[i*W +: W] = 32'h8000_0001 + i; in_b[i*W +: W] = 32'h20 + i; end
      endcase
    end
  endtask

  // Drive one instruction; hold: keep valid with junk while busy (ignored)
  task automatic send(int op, logic [L-1:0] mask, int mode, bit junk, bit b2b);
    @(negedge clk);
    in_op = 3'(op); in_mask = mask; fill(mode); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    if (junk) begin
      cur_tag = "R2";
      for (int k = 0; k < 3; k++) begin
        in_op = 3'($urandom); in_mask = $urandom; fill(0);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end else if (!b2b) begin
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);      // R9 checked while in reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cur_tag = "R5";
    for (int op = 0; op < 5; op++) begin
      send(op, '1, 0, 0, 0); drain();
    end
    send(0, '1, 1, 0, 0); drain();  // R5 wrap-around add
    cur_tag = "R6";
    send(5, '1, 2, 0, 0); drain();  // R6 shift amount uses low 5 bits of B
    send(5, '1, 0, 0, 0); drain();
    cur_tag = "R7";
    send(6, 32'hFFFF_0000, 0, 0, 0); drain();
    send(7, 32'h0000_FFFF, 0, 0, 0); drain();
    cur_tag = "R8";
    send(0, '1, 0, 0, 0); drain();
    send(4, 32'hA5A5_5A5A, 0, 0, 0); drain();
    send(1, 32'h0, 0, 0, 0); drain();
    send(2, 32'h8000_0001, 0, 0, 0); drain();
    send(3, '1, 0, 1, 0); drain();  // R2 inputs during busy ignored
    cur_tag = "R10";
    send(0, '1, 0, 0, 1);           // back-to-back
    send(1, 32'h0F0F_F0F0, 0, 0, 1);
    send(5, '1, 2, 0, 0);
    drain();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end
endmodule